// File: doc/BRIEF.md
# Arithmetic/Logic Unit with Condition Flags

This block is the integer execute stage of a small processor datapath. It combines two operands under a 4-bit function select and drives the result combinationally. In the same cycle it forms three flags from that result: zero, sign and signed overflow. A clock edge with the flag-update enable high copies the flags into a 3-bit condition register. A separate 4-bit condition select is decoded against the stored flags only, never the live ones. The decode gives a single "take" bit. Conditional register moves and conditional branches both use this one bit, so they share the same signed-comparison decode.

The data width is a parameter, 64 bits by default. Sign and overflow always refer to the most significant bit. The subtract operation returns the second operand minus the first, so a compare-and-branch sequence reads naturally as "B compared with A".

Top module: `alu_cc_unit`

## Requirements
- R1: Function code 0 gives op_a + op_b, 1 gives a subtraction, 2 gives op_a AND op_b, and 3 gives op_a XOR op_b. All results are taken modulo 2^WIDTH.
- R2: The subtraction computes op_b minus op_a, not op_a minus op_b.
- R3: Any function code from 4 to 15 drives a result of zero, with live flags Z=1, S=0 and O=0.
- R4: flag_z is 1 exactly when the result is all zeros. flag_s equals the result's most significant bit (bit 63 at the default width).
- R5: For addition, flag_o is 1 exactly when both operands have the same sign and the result's sign differs from op_a's sign.
- R6: For subtraction, flag_o is 1 exactly when the operands' signs differ and the result's sign differs from op_b's sign.
- R7: For AND and XOR, flag_o is always 0.
- R8: When cc_we is high at a rising clock edge, cc_q loads the live flags packed as {Z,S,O}, with Z in bit 2, S in bit 1 and O in bit 0.
- R9: When cc_we is low at a rising clock edge, cc_q keeps its value.
- R10: A synchronous active-high reset sets cc_q to 3'b100 (Z=1, S=0, O=0). Reset takes priority over cc_we.
- R11: cond_sel values 1 to 6 evaluate, in that order: (S^O)|Z, S^O, Z, !Z, !(S^O), and !(S^O)&!Z.
- R12: cond_sel 0 always gives cond_true=1. Any cond_sel from 7 to 15 gives cond_true=0.
- R13: cond_true depends only on cc_q and cond_sel. The live flags of the current operation do not affect it until they have been loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_a | input | WIDTH | First operand (subtrahend for subtract) |
| op_b | input | WIDTH | Second operand |
| fn_code | input | 4 | Operation select |
| cc_we | input | 1 | Load live flags into the condition register at the clock edge |
| cond_sel | input | 4 | Condition to test against the stored flags |
| result | output | WIDTH | Combinational operation result |
| flag_z | output | 1 | Live zero flag |
| flag_s | output | 1 | Live sign flag |
| flag_o | output | 1 | Live signed-overflow flag |
| cc_q | output | 3 | Stored flags {Z,S,O} |
| cond_true | output | 1 | Selected condition holds on the stored flags |

## Verification
The bench runs at a 4-bit width and sweeps every operand pair under every function code. After each load it decodes all 16 condition selects against the flags it expects to be stored. This sweep reaches the corners a wrong design would miss:
- Reversed subtraction operands give negated results and swapped signs.
- A subtract overflow rule that tests the wrong operand's sign misreports cases such as 0 minus the most negative value.
- A sum that wraps to zero with overflow (most negative plus most negative) exposes mixed-up Z and O packing.
- Live flags leaking into the condition decode are caught, because the bench always presents a new operation before it samples the decode.

Vectors with the enable held low, and a reset asserted together with the enable, confirm that the register holds its value and that reset wins.

// File: rtl/alu_cc_pkg.sv
package alu_cc_pkg;

  localparam logic [3:0] FN_ADD = 4'd0;
  localparam logic [3:0] FN_SUB = 4'd1;
  localparam logic [3:0] FN_AND = 4'd2;
  localparam logic [3:0] FN_XOR = 4'd3;

  localparam logic [3:0] CND_ALWAYS = 4'd0;
  localparam logic [3:0] CND_LE     = 4'd1;
  localparam logic [3:0] CND_LT     = 4'd2;
  localparam logic [3:0] CND_EQ     = 4'd3;
  localparam logic [3:0] CND_NE     = 4'd4;
  localparam logic [3:0] CND_GE     = 4'd5;
  localparam logic [3:0] CND_GT     = 4'd6;

  // Packed so that z lands in the most significant bit.
  typedef struct packed {
    logic z;
    logic s;
    logic o;
  } ccode_t;

  localparam ccode_t CC_RESET = '{z: 1'b1, s: 1'b0, o: 1'b0};

endpackage

// File: rtl/alu_datapath.sv
module alu_datapath
  import alu_cc_pkg::*;
#(
  parameter int WIDTH        = 64,
  parameter bit SHARED_ADDER = 1'b1
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic [3:0]       fn,
  output logic [WIDTH-1:0] y
);

  logic [WIDTH-1:0] arith;
  logic             is_sub;

  assign is_sub = (fn == FN_SUB);

  generate
    if (SHARED_ADDER) begin : g_shared
      // One carry chain: b + ~a + 1 for subtract, b + a for add.
      logic [WIDTH-1:0] addend;
      logic [WIDTH-1:0] cin;
      assign addend = is_sub ? ~a : a;
      assign cin    = {{(WIDTH-1){1'b0}}, is_sub};
      assign arith  = b + addend + cin;
    end else begin : g_split
      assign arith = is_sub ? (b - a) : (a + b);
    end
  endgenerate

  always_comb begin
    case (fn)
      FN_ADD,
      FN_SUB:  y = arith;
      FN_AND:  y = a & b;
      FN_XOR:  y = a ^ b;
      default: y = '0;
    endcase
  end

endmodule

// File: rtl/alu_flag_gen.sv
module alu_flag_gen
  import alu_cc_pkg::*;
#(
  parameter int WIDTH = 64
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic [WIDTH-1:0] y,
  input  logic [3:0]       fn,
  output ccode_t           flags
);

  localparam int MSB = WIDTH - 1;

  logic sa, sb, sy;

  assign sa = a[MSB];
  assign sb = b[MSB];
  assign sy = y[MSB];

  always_comb begin
    flags.z = (y == '0);
    flags.s = sy;
    case (fn)
      FN_ADD:  flags.o = (sa == sb) && (sy != sa);
      FN_SUB:  flags.o = (sa != sb) && (sy != sb);
      default: flags.o = 1'b0;
    endcase
  end

endmodule

// File: rtl/cc_store.sv
module cc_store
  import alu_cc_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   we,
  input  ccode_t d,
  output ccode_t q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= CC_RESET;
    end else if (we) begin
      q <= d;
    end
  end

endmodule

// File: rtl/cond_eval.sv
module cond_eval
  import alu_cc_pkg::*;
(
  input  ccode_t     cc,
  input  logic [3:0] sel,
  output logic       take
);

  logic lt;

  assign lt = cc.s ^ cc.o;

  always_comb begin
    case (sel)
      CND_ALWAYS: take = 1'b1;
      CND_LE:     take = lt | cc.z;
      CND_LT:     take = lt;
      CND_EQ:     take = cc.z;
      CND_NE:     take = ~cc.z;
      CND_GE:     take = ~lt;
      CND_GT:     take = ~lt & ~cc.z;
      default:    take = 1'b0;
    endcase
  end

endmodule

// File: rtl/alu_cc_unit.sv
module alu_cc_unit
  import alu_cc_pkg::*;
#(
  parameter int WIDTH        = 64,
  parameter bit SHARED_ADDER = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic [3:0]       fn_code,
  input  logic             cc_we,
  input  logic [3:0]       cond_sel,
  output logic [WIDTH-1:0] result,
  output logic             flag_z,
  output logic             flag_s,
  output logic             flag_o,
  output logic [2:0]       cc_q,
  output logic             cond_true
);

  ccode_t live_cc;
  ccode_t held_cc;

  alu_datapath #(
    .WIDTH        (WIDTH),
    .SHARED_ADDER (SHARED_ADDER)
  ) u_dp (
    .a  (op_a),
    .b  (op_b),
    .fn (fn_code),
    .y  (result)
  );

  alu_flag_gen #(
    .WIDTH (WIDTH)
  ) u_flags (
    .a     (op_a),
    .b     (op_b),
    .y     (result),
    .fn    (fn_code),
    .flags (live_cc)
  );

  cc_store u_ccr (
    .clk (clk),
    .rst (rst),
    .we  (cc_we),
    .d   (live_cc),
    .q   (held_cc)
  );

  cond_eval u_cond (
    .cc   (held_cc),
    .sel  (cond_sel),
    .take (cond_true)
  );

  assign flag_z = live_cc.z;
  assign flag_s = live_cc.s;
  assign flag_o = live_cc.o;
  assign cc_q   = held_cc;

endmodule

// File: rtl/alu_cc_unit_chk.sv
module alu_cc_unit_chk #(
  parameter int WIDTH = 64
) (
  input logic             clk,
  input logic             rst,
  input logic [3:0]       fn_code,
  input logic             cc_we,
  input logic [3:0]       cond_sel,
  input logic [WIDTH-1:0] result,
  input logic             flag_z,
  input logic             flag_s,
  input logic             flag_o,
  input logic [2:0]       cc_q,
  input logic             cond_true
);

  logic rst_seen_q;

  always_ff @(posedge clk) begin
    rst_seen_q <= rst;
  end

  // R10: the cycle after a reset edge shows the reset flags
  always_ff @(posedge clk) begin
    if (rst_seen_q === 1'b1) begin
      p_reset_value_r10: assert (cc_q == 3'b100)
        else $error("cc_q not at reset value");
    end
  end

  // R8
  p_load_flags_r8: assert property (@(posedge clk) disable iff (rst)
    cc_we |=> cc_q == {$past(flag_z), $past(flag_s), $past(flag_o)});

  // R9
  p_hold_flags_r9: assert property (@(posedge clk) disable iff (rst)
    !cc_we |=> $stable(cc_q));

  // R3
  p_unknown_fn_r3: assert property (@(posedge clk) disable iff (rst)
    (fn_code > 4'd3) |-> (result == '0 && flag_z && !flag_s && !flag_o));

  // R7
  p_logic_no_ovf_r7: assert property (@(posedge clk) disable iff (rst)
    (fn_code == 4'd2 || fn_code == 4'd3) |-> !flag_o);

  // R12
  p_always_r12: assert property (@(posedge clk) disable iff (rst)
    (cond_sel == 4'd0) |-> cond_true);

  // R12
  p_never_r12: assert property (@(posedge clk) disable iff (rst)
    (cond_sel > 4'd6) |-> !cond_true);

  // R11
  p_equal_r11: assert property (@(posedge clk) disable iff (rst)
    (cond_sel == 4'd3) |-> (cond_true == cc_q[2]));

endmodule

bind alu_cc_unit alu_cc_unit_chk #(.WIDTH(WIDTH)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .fn_code   (fn_code),
  .cc_we     (cc_we),
  .cond_sel  (cond_sel),
  .result    (result),
  .flag_z    (flag_z),
  .flag_s    (flag_s),
  .flag_o    (flag_o),
  .cc_q      (cc_q),
  .cond_true (cond_true)
);

// File: tb/alu_cc_unit_test.sv
`timescale 1ns/1ps
module alu_cc_unit_test;

  localparam int W    = 4;
  localparam int MASK = (1 << W) - 1;
  localparam int MSBV = 1 << (W - 1);

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] op_a = '0;
  logic [W-1:0] op_b = '0;
  logic [3:0]   fn_code = '0;
  logic         cc_we = 1'b0;
  logic [3:0]   cond_sel = '0;
  logic [W-1:0] result;
  logic         flag_z, flag_s, flag_o;
  logic [2:0]   cc_q;
  logic         cond_true;

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  done   = 1'b0;

  always #2.5 clk = ~clk;

  alu_cc_unit #(.WIDTH(W)) uut (
    .clk       (clk),
    .rst       (rst),
    .op_a      (op_a),
    .op_b      (op_b),
    .fn_code   (fn_code),
    .cc_we     (cc_we),
    .cond_sel  (cond_sel),
    .result    (result),
    .flag_z    (flag_z),
    .flag_s    (flag_s),
    .flag_o    (flag_o),
    .cc_q      (cc_q),
    .cond_true (cond_true)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (a=%0d b=%0d fn=%0d sel=%0d)",
               req, act, exp, op_a, op_b, fn_code, cond_sel);
    end
  endtask

  function automatic bit cond_model(input int sel, input int cc);
    bit z, s, o, lt;
    z  = cc[2];
    s  = cc[1];
    o  = cc[0];
    lt = s ^ o;
    case (sel)
      0:       return 1'b1;
      1:       return lt | z;
      2:       return lt;
      3:       return z;
      4:       return !z;
      5:       return !lt;
      6:       return !lt && !z;
      default: return 1'b0;
    endcase
  endfunction

  // R11 R12 R13: sweep every select against the stored value
  task automatic sweep_conds(input int exp_cc);
    for (int sel = 0; sel < 16; sel++) begin
      cond_sel = 4'(sel);
      #0.1;
      if (sel == 0 || sel > 6)
        check("R12", int'(cond_true), int'(cond_model(sel, exp_cc)));
      else
        check("R11/R13", int'(cond_true), int'(cond_model(sel, exp_cc)));
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    int exp_cc;
    int vec;
    exp_cc = 4;
    vec    = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R10", int'(cc_q), 4);
    sweep_conds(4);

    for (int f = 0; f < 16; f++) begin
      for (int a = 0; a < 16; a++) begin
        for (int b = 0; b < 16; b++) begin
          int  r, o, sa, sb, sr;
          bit  we;
          @(negedge clk);
          we      = (vec % 7) != 3;
          op_a    = 4'(a);
          op_b    = 4'(b);
          fn_code = 4'(f);
          cc_we   = we;
          #0.2;
          sa = (a & MSBV) != 0;
          sb = (b & MSBV) != 0;
          case (f)
            0: r = (a + b) & MASK;
            1: r = (b - a) & MASK;
            2: r = a & b;
            3: r = a ^ b;
            default: r = 0;
          endcase
          sr = (r & MSBV) != 0;
          case (f)
            0: o = (sa == sb) && (sr != sa);
            1: o = (sa != sb) && (sr != sb);
            default: o = 0;
          endcase
          if (f == 1)      check("R2", int'(result), r);
          else if (f > 3)  check("R3", int'(result), r);
          else             check("R1", int'(result), r);
          check("R4 zero", int'(flag_z), int'(r == 0));
          check("R4 sign", int'(flag_s), sr);
          if (f == 0)      check("R5", int'(flag_o), o);
          else if (f == 1) check("R6", int'(flag_o), o);
          else             check("R7", int'(flag_o), 0);
          // stored flags still reflect the previous load, not this op
          check(we ? "R8" : "R9", int'(cc_q), exp_cc);
          sweep_conds(exp_cc);
          if (we) exp_cc = ((r == 0) << 2) | (sr << 1) | o;
          vec++;
        end
      end
    end

    @(negedge clk);
    check("R8 last", int'(cc_q), exp_cc);

    // R10: reset wins over a simultaneous load of different flags
    op_a    = 4'd8;
    op_b    = 4'd8;
    fn_code = 4'd0;
    cc_we   = 1'b1;
    rst     = 1'b1;
    @(negedge clk);
    check("R10 priority", int'(cc_q), 4);
    rst   = 1'b0;
    @(negedge clk);
    // R8: sum wraps to zero with overflow -> Z=1 S=0 O=1
    check("R8 pack", int'(cc_q), 5);
    cc_we = 1'b0;

    done = 1'b1;
    finish_run();
  end

endmodule